// File: doc/BRIEF.md
# Always-On Seconds-Fraction Counter with Power-Off Request

This block is a small always-on timekeeping peripheral. It holds a 47-bit counter that advances on every enabled tick of a 32,768 Hz slow clock. Software reaches it through a 32-bit register window of 4 KB. The counter is split across two registers, and writing either register reloads only its own half of the live count.

A control register keeps whatever software writes to it. A control write that sets both the turn-off bit and the power-down-enable bit in the same word sends out a one-cycle shutdown request. Reset clears the control register but leaves the count as it was, so time survives a reset of the surrounding logic.

Read data comes out of a register one cycle after the address is presented. Only word-aligned offsets are decoded.

Top module: `aon_rtc`

## Requirements
- R1: On each clock edge where `tick_en` is high and no counter write occurs, the counter increases by one, with a carry from bit 31 into bit 32. When `tick_en` is low and no write occurs, the counter holds its value.
- R2: The counter is 47 bits wide and wraps from all ones to zero.
- R3: Read data is registered and appears one cycle after the address. Offset 0x00 returns counter bits 46:32 in bits 14:0, with zeros above. Offset 0x04 returns counter bits 31:0.
- R4: A write to offset 0x04 replaces counter bits 31:0 with the written data and leaves bits 46:32 unchanged.
- R5: A write to offset 0x00 loads bits 14:0 of the written data into counter bits 46:32. It ignores written bits 31:15 and leaves counter bits 31:0 unchanged.
- R6: A counter write in the same cycle as a tick takes priority, so the written value is stored without an increment.
- R7: A write to offset 0x08 stores all 32 bits into the control register, and reading 0x08 returns them unchanged.
- R8: `shutdown_req` is high for exactly the one cycle after the edge that captures a control write with bit 6 (turn-off) and bit 5 (power-down enable) both set. A control write with only one of these bits set, or with neither, produces no pulse.
- R9: Synchronous reset clears the control register, `rd_data` and `shutdown_req`. It does not change the counter.
- R10: Unaligned offsets (address bits 1:0 not zero) and aligned offsets other than 0x00, 0x04 and 0x08 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable per 32,768 Hz slow-clock tick |
| bus_addr | input | 12 | Byte offset in the register window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous cycle's address |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
The counter is preloaded with distinct values in each half, then read back. This shows that each write reaches only its own half, and that the ignored upper write bits are really dropped.

Runs of ticks are tried from three starting points:
- a plain value, which checks counting;
- 0xFFFFFFFF in the low half, which checks the carry into bit 32;
- all ones short of two, which checks the 47-bit wrap.

A write that lands on a tick separates priority to the write from a write followed by an increment.

The control word is written with neither power bit, with each bit alone, and with both bits. Only the last may pulse. Unaligned and unmapped writes are followed by reads of the registers they could have corrupted.

// File: rtl/aon_rtc_pkg.sv
package aon_rtc_pkg;
  localparam logic [11:0] OFS_CNT_HI = 12'h000;
  localparam logic [11:0] OFS_CNT_LO = 12'h004;
  localparam logic [11:0] OFS_CTRL   = 12'h008;
  localparam int CTRL_TURN_OFF_BIT = 6;
  localparam int CTRL_PD_EN_BIT    = 5;

  typedef struct packed {
    logic hi;
    logic lo;
    logic ctrl;
  } rtc_sel_t;
endpackage

// File: rtl/aon_rtc_decode.sv
module aon_rtc_decode
  import aon_rtc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output rtc_sel_t          rd_sel,
  output rtc_sel_t          wr_sel
);
  logic aligned;

  always_comb begin
    aligned     = (addr[1:0] == 2'b00);
    rd_sel.hi   = aligned && (addr == ADDR_W'(OFS_CNT_HI));
    rd_sel.lo   = aligned && (addr == ADDR_W'(OFS_CNT_LO));
    rd_sel.ctrl = aligned && (addr == ADDR_W'(OFS_CTRL));
    wr_sel.hi   = wr && rd_sel.hi;
    wr_sel.lo   = wr && rd_sel.lo;
    wr_sel.ctrl = wr && rd_sel.ctrl;
  end
endmodule

// File: rtl/aon_rtc_counter.sv
module aon_rtc_counter #(
  parameter int CNT_W  = 47,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              we_hi,
  input  logic              we_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] cnt_q;

  // No reset: the count is preserved across a reset of the bus logic.
  always_ff @(posedge clk) begin
    if (we_lo)
      cnt_q <= {cnt_q[CNT_W-1:DATA_W], wdata};
    else if (we_hi)
      cnt_q <= {wdata[HI_W-1:0], cnt_q[DATA_W-1:0]};
    else if (tick_en)
      cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !we_hi && !we_lo) |=> (count == $past(count) + 1'b1)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !we_hi && !we_lo) |=> $stable(count)); // R1
  AST_LO_LOAD: assert property (@(posedge clk) disable iff (rst)
    we_lo |=> (count[DATA_W-1:0] == $past(wdata)) && (count[CNT_W-1:DATA_W] == $past(count[CNT_W-1:DATA_W]))); // R4
  AST_HI_LOAD: assert property (@(posedge clk) disable iff (rst)
    (we_hi && !we_lo) |=> (count[CNT_W-1:DATA_W] == $past(wdata[HI_W-1:0])) && (count[DATA_W-1:0] == $past(count[DATA_W-1:0]))); // R5
endmodule

// File: rtl/aon_rtc_ctrl.sv
module aon_rtc_ctrl
  import aon_rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl,
  output logic              shutdown
);
  logic [DATA_W-1:0] ctrl_q;
  logic              sd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      sd_q   <= 1'b0;
    end else begin
      if (we) ctrl_q <= wdata;
      sd_q <= we && wdata[CTRL_TURN_OFF_BIT] && wdata[CTRL_PD_EN_BIT];
    end
  end

  assign ctrl     = ctrl_q;
  assign shutdown = sd_q;

  AST_SD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(shutdown) |-> $past(we)); // R8
  AST_CTRL_CLEAR: assert property (@(posedge clk)
    rst |=> (ctrl == '0) && !shutdown); // R9
  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(ctrl)); // R7
endmodule

// File: rtl/aon_rtc.sv
module aon_rtc
  import aon_rtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 47
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              shutdown_req
);
  localparam int HI_W = CNT_W - DATA_W;

  rtc_sel_t          rd_sel, wr_sel;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] ctrl;
  logic [DATA_W-1:0] rd_q;

  aon_rtc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd_sel(rd_sel), .wr_sel(wr_sel));

  aon_rtc_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .we_hi(wr_sel.hi),
    .we_lo(wr_sel.lo), .wdata(bus_wdata), .count(count));

  aon_rtc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .we(wr_sel.ctrl), .wdata(bus_wdata),
    .ctrl(ctrl), .shutdown(shutdown_req));

  always_ff @(posedge clk) begin
    if (rst)              rd_q <= '0;
    else if (rd_sel.hi)   rd_q <= {{(DATA_W-HI_W){1'b0}}, count[CNT_W-1:DATA_W]};
    else if (rd_sel.lo)   rd_q <= count[DATA_W-1:0];
    else if (rd_sel.ctrl) rd_q <= ctrl;
    else                  rd_q <= '0;
  end

  assign rd_data = rd_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(rd_sel.hi || rd_sel.lo || rd_sel.ctrl) |=> (rd_data == '0)); // R10
  AST_HI_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    rd_sel.hi |=> (rd_data[DATA_W-1:HI_W] == '0)); // R3
endmodule

// File: tb/aon_rtc_test.sv
module aon_rtc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic        shutdown_req;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  logic [31:0] q_exp[$];
  int          q_cyc[$];
  string       q_tag[$];

  aon_rtc uut (.clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .shutdown_req(shutdown_req));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data once the capturing edge has passed.
  always @(negedge clk) begin
    if (q_exp.size() > 0 && q_cyc[0] < cyc) begin
      check(q_tag[0], rd_data, q_exp[0]);
      void'(q_exp.pop_front());
      void'(q_cyc.pop_front());
      void'(q_tag.pop_front());
    end
  end

  // Driver tasks: each starts and ends just after a falling edge.
  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    bus_addr = a;
    q_exp.push_back(exp);
    q_cyc.push_back(cyc);
    q_tag.push_back(tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, bit exp_sd, string tag);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check(tag, {31'd0, shutdown_req}, {31'd0, exp_sd});
    @(negedge clk);
    if (exp_sd) check({tag, " pulse end"}, {31'd0, shutdown_req}, 32'd0);
  endtask

  task automatic ticks(int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset rd_data", rd_data, 32'd0);
    check("R9 reset shutdown", {31'd0, shutdown_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    wr(12'h004, 32'h1234_5678, 0, "R4 lo write");
    wr(12'h000, 32'hFFFF_8005, 0, "R5 hi write");
    rd(12'h000, 32'h0000_0005, "R5 hi ignores bits 31:15");
    rd(12'h004, 32'h1234_5678, "R4 lo value");

    ticks(10);
    rd(12'h004, 32'h1234_5682, "R1 ten ticks");
    rd(12'h004, 32'h1234_5682, "R1 hold without tick");
    rd(12'h000, 32'h0000_0005, "R3 hi read");

    wr(12'h004, 32'hFFFF_FFFF, 0, "R1 carry setup");
    wr(12'h000, 32'h0000_0010, 0, "R1 carry setup hi");
    ticks(1);
    rd(12'h000, 32'h0000_0011, "R1 carry into bit 32");
    rd(12'h004, 32'h0000_0000, "R1 carry low half");

    wr(12'h000, 32'h0000_7FFF, 0, "R2 wrap setup hi");
    wr(12'h004, 32'hFFFF_FFFE, 0, "R2 wrap setup lo");
    ticks(3);
    rd(12'h000, 32'h0000_0000, "R2 wrap hi");
    rd(12'h004, 32'h0000_0001, "R2 wrap lo");

    tick_en = 1'b1;
    wr(12'h004, 32'hABCD_0000, 0, "R6 write with tick");
    tick_en = 1'b0;
    rd(12'h004, 32'hABCD_0001, "R6 write wins then one tick");
    tick_en = 1'b1;
    bus_addr = 12'h004; bus_wdata = 32'h0000_0100; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
    @(negedge clk);
    rd(12'h004, 32'h0000_0100, "R6 no increment on write cycle");

    wr(12'h008, 32'hDEAD_BE9F, 0, "R8 no power bits");
    rd(12'h008, 32'hDEAD_BE9F, "R7 ctrl readback");
    wr(12'h008, 32'h0000_0020, 0, "R8 pd_en only");
    wr(12'h008, 32'h0000_0040, 0, "R8 turn_off only");
    wr(12'h008, 32'h8000_0060, 1, "R8 both bits");
    rd(12'h008, 32'h8000_0060, "R7 ctrl full word");

    wr(12'h00C, 32'hFFFF_FFFF, 0, "R10 unmapped write");
    rd(12'h00C, 32'h0000_0000, "R10 unmapped read");
    wr(12'h006, 32'h5555_5555, 0, "R10 unaligned write lo");
    rd(12'h004, 32'h0000_0100, "R10 lo untouched");
    wr(12'h00A, 32'h0000_0060, 0, "R10 unaligned ctrl no pulse");
    rd(12'h008, 32'h8000_0060, "R10 ctrl untouched");
    rd(12'hFFC, 32'h0000_0000, "R10 top of window");
    rd(12'h002, 32'h0000_0000, "R10 unaligned read");

    wr(12'h000, 32'h0000_1234, 0, "R9 setup hi");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 rd_data in reset", rd_data, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    rd(12'h008, 32'h0000_0000, "R9 ctrl cleared");
    rd(12'h000, 32'h0000_1234, "R9 counter hi kept");
    rd(12'h004, 32'h0000_0100, "R9 counter lo kept");

    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule